// File: doc/BRIEF.md
# Indirect-Addressed Scratchpad Register File

This block holds sixty-four 8-bit working registers for a small 8-bit processor core. It also holds a 6-bit pointer that is treated as two octal digits. Each access carries a 4-bit select code taken from the instruction word:

- Codes below twelve name a fixed register directly.
- Codes 12, 13 and 14 use the pointer to choose the register.
- Code 13 steps the pointer's low digit up after the access, and code 14 steps it down. In both cases the upper digit never changes.
- Code 15 is reserved and does nothing.

Loop code uses a status output to test whether the low digit has reached seven.

Two fixed register pairs can also be read and written as 16-bit words. The processor uses them as return-address and data-pointer holders. The pointer can be loaded in three ways: one digit at a time from a 3-bit constant, or whole from six accumulator bits. It can be read back zero-extended to a byte. Decoding, arithmetic and memory traffic belong to other blocks.

Top module: `sp_scratch`

## Requirements
- R1: After reset the pointer is 0 and every register reads 0.
- R2: Codes 0 to 11 select register 0 to 11. `rd_data` shows the selected register in the same cycle whenever the code is legal, and `rd_en` does not gate it. A write with `wr_en` is visible from the next cycle.
- R3: Code 12 selects the register whose index is the pointer (upper digit in bits 5:3, lower digit in bits 2:0). An access with code 12 leaves the pointer unchanged, and so does an access with codes 0 to 11.
- R4: An access (`rd_en` or `wr_en`) with code 13 uses the pointer's current value and then adds one to its low digit. Seven wraps to zero and the upper digit does not change.
- R5: An access with code 14 uses the current pointer and then subtracts one from its low digit. Zero wraps to seven and the upper digit does not change.
- R6: Code 15 writes nothing, drives `rd_data` to 0 and leaves the pointer unchanged.
- R7: `ptr_ld_hi` loads the upper digit from `ptr_digit`, and `ptr_ld_lo` loads the lower digit from it. Each load leaves the other digit alone. A lower-digit load overrides a step in the same cycle.
- R8: `ptr_ld_full` loads all six bits from `ptr_full_in` and overrides every other pointer update in that cycle. `ptr_out` is the pointer with two zero bits on top.
- R9: `lo_not7` is 1 exactly when the pointer's low digit differs from 7.
- R10: When `pair_sel` is 0, `pair_rd_data` is {register 12, register 13}. When `pair_sel` is 1, it is {register 14, register 15}. In both cases the upper byte is the lower-numbered register. `pair_wr_en` writes both bytes of the chosen pair, and a byte write to the same register in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_code | input | 4 | Register select code from the instruction |
| rd_en | input | 1 | Read access (triggers a pointer step with codes 13/14) |
| wr_en | input | 1 | Byte write to the selected register |
| wr_data | input | 8 | Byte write data |
| rd_data | output | 8 | Selected register contents (0 for code 15) |
| pair_sel | input | 1 | 0 picks pair 12/13, 1 picks pair 14/15 |
| pair_wr_en | input | 1 | 16-bit write to the chosen pair |
| pair_wr_data | input | 16 | Pair write data, upper byte to the lower-numbered register |
| pair_rd_data | output | 16 | Chosen pair contents |
| ptr_ld_hi | input | 1 | Load upper pointer digit |
| ptr_ld_lo | input | 1 | Load lower pointer digit |
| ptr_digit | input | 3 | Digit value for the digit loads |
| ptr_ld_full | input | 1 | Load the whole pointer |
| ptr_full_in | input | 6 | Whole-pointer load value |
| ptr_out | output | 8 | Pointer, zero-extended |
| lo_not7 | output | 1 | Pointer low digit is not 7 |

## Verification
A long random stream mixes all sixteen select codes with reads, writes, digit loads, full loads and pair writes. This shows whether direct and indirect addressing reach the same storage, and whether the pointer is still updated correctly when several sources compete in one cycle.

Directed sequences cover the cases random traffic rarely reaches:
- Stepping up from a low digit of 7 and down from 0. This separates a digit-local wrap from a carry or borrow into the upper digit.
- A write attempt with code 15, which must leave the stored value unchanged.
- A pair write that collides with a byte write, which shows which one takes precedence.
- A read on a stepping code, which shows that the address used is the one before the step.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int DIGIT_W = 3;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 4;

    localparam logic [SEL_W-1:0] SEL_IND_HOLD = 4'd12;
    localparam logic [SEL_W-1:0] SEL_IND_UP   = 4'd13;
    localparam logic [SEL_W-1:0] SEL_IND_DOWN = 4'd14;
    localparam logic [SEL_W-1:0] SEL_NONE     = 4'd15;

    localparam int PAIR0_BASE = 12;
    localparam int PAIR1_BASE = 14;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/sp_decode.sv
module sp_decode
    import sp_pkg::*;
#(
    parameter int DIGIT_W = sp_pkg::DIGIT_W,
    localparam int PTR_W = 2 * DIGIT_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] addr,
    output logic             legal,
    output step_e            step
);
    always_comb begin
        addr  = ptr;
        legal = 1'b1;
        step  = STEP_NONE;
        if (sel < SEL_IND_HOLD) begin
            addr = PTR_W'(sel);
        end else if (sel == SEL_IND_UP) begin
            step = STEP_UP;
        end else if (sel == SEL_IND_DOWN) begin
            step = STEP_DOWN;
        end else if (sel == SEL_NONE) begin
            legal = 1'b0;
        end
    end
endmodule

// File: rtl/sp_ptr.sv
module sp_ptr
    import sp_pkg::*;
#(
    parameter int DIGIT_W = sp_pkg::DIGIT_W,
    localparam int PTR_W = 2 * DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  step_e              step,
    input  logic               ld_hi,
    input  logic               ld_lo,
    input  logic [DIGIT_W-1:0] digit,
    input  logic               ld_full,
    input  logic [PTR_W-1:0]   full_val,
    output logic [PTR_W-1:0]   ptr
);
    typedef struct packed {
        logic [DIGIT_W-1:0] hi;
        logic [DIGIT_W-1:0] lo;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        case (step)
            STEP_UP:   ptr_d.lo = ptr_q.lo + DIGIT_W'(1);
            STEP_DOWN: ptr_d.lo = ptr_q.lo - DIGIT_W'(1);
            default:   ;
        endcase
        if (ld_hi)   ptr_d.hi = digit;
        if (ld_lo)   ptr_d.lo = digit;
        if (ld_full) ptr_d    = ptr_t'(full_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/sp_regfile.sv
module sp_regfile
    import sp_pkg::*;
#(
    parameter int DIGIT_W = sp_pkg::DIGIT_W,
    parameter int DATA_W  = sp_pkg::DATA_W,
    localparam int PTR_W = 2 * DIGIT_W,
    localparam int DEPTH = 1 << PTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PTR_W-1:0]    addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                pair_sel,
    input  logic                pair_we,
    input  logic [2*DATA_W-1:0] pair_wdata,
    output logic [2*DATA_W-1:0] pair_rdata
);
    localparam logic [PTR_W-1:0] BASE0 = PTR_W'(PAIR0_BASE);
    localparam logic [PTR_W-1:0] BASE1 = PTR_W'(PAIR1_BASE);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [PTR_W-1:0]  pidx_hi, pidx_lo;

    assign pidx_hi = pair_sel ? BASE1 : BASE0;
    assign pidx_lo = pidx_hi + PTR_W'(1);

    always_comb begin
        mem_d = mem_q;
        if (pair_we) begin
            mem_d[pidx_hi] = pair_wdata[2*DATA_W-1:DATA_W];
            mem_d[pidx_lo] = pair_wdata[DATA_W-1:0];
        end
        if (we) mem_d[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata      = mem_q[addr];
    assign pair_rdata = {mem_q[pidx_hi], mem_q[pidx_lo]};
endmodule

// File: rtl/sp_scratch.sv
module sp_scratch
    import sp_pkg::*;
#(
    parameter int DIGIT_W = sp_pkg::DIGIT_W,
    parameter int DATA_W  = sp_pkg::DATA_W,
    localparam int PTR_W = 2 * DIGIT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          sel_code,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                pair_sel,
    input  logic                pair_wr_en,
    input  logic [2*DATA_W-1:0] pair_wr_data,
    output logic [2*DATA_W-1:0] pair_rd_data,
    input  logic                ptr_ld_hi,
    input  logic                ptr_ld_lo,
    input  logic [DIGIT_W-1:0]  ptr_digit,
    input  logic                ptr_ld_full,
    input  logic [PTR_W-1:0]    ptr_full_in,
    output logic [DATA_W-1:0]   ptr_out,
    output logic                lo_not7
);
    logic [PTR_W-1:0]  ptr, addr;
    logic              legal;
    step_e             dec_step, step;
    logic [DATA_W-1:0] raw_rd;

    sp_decode #(.DIGIT_W(DIGIT_W)) u_dec (
        .sel(sel_code), .ptr(ptr), .addr(addr), .legal(legal), .step(dec_step)
    );

    assign step = (rd_en || wr_en) ? dec_step : STEP_NONE;

    sp_ptr #(.DIGIT_W(DIGIT_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .step(step),
        .ld_hi(ptr_ld_hi), .ld_lo(ptr_ld_lo), .digit(ptr_digit),
        .ld_full(ptr_ld_full), .full_val(ptr_full_in), .ptr(ptr)
    );

    sp_regfile #(.DIGIT_W(DIGIT_W), .DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .we(wr_en && legal), .wdata(wr_data), .rdata(raw_rd),
        .pair_sel(pair_sel), .pair_we(pair_wr_en),
        .pair_wdata(pair_wr_data), .pair_rdata(pair_rd_data)
    );

    assign rd_data = legal ? raw_rd : '0;
    assign ptr_out = DATA_W'(ptr);
    assign lo_not7 = (ptr[DIGIT_W-1:0] != {DIGIT_W{1'b1}});
endmodule

// File: rtl/sp_scratch_chk.sv
module sp_scratch_chk #(
    parameter int DIGIT_W = 3,
    parameter int DATA_W  = 8,
    localparam int PTR_W = 2 * DIGIT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        sel_code,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              ptr_ld_hi,
    input logic              ptr_ld_lo,
    input logic              ptr_ld_full,
    input logic [PTR_W-1:0]  ptr_full_in,
    input logic [DATA_W-1:0] ptr_out
);
    logic no_ld, acc;
    assign no_ld = !ptr_ld_hi && !ptr_ld_lo && !ptr_ld_full;
    assign acc   = rd_en || wr_en;

    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_code == 4'd13 && no_ld) |=>
        (ptr_out[DIGIT_W-1:0] == DIGIT_W'($past(ptr_out[DIGIT_W-1:0]) + DIGIT_W'(1)))
        && (ptr_out[PTR_W-1:DIGIT_W] == $past(ptr_out[PTR_W-1:DIGIT_W])));

    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_code == 4'd14 && no_ld) |=>
        (ptr_out[DIGIT_W-1:0] == DIGIT_W'($past(ptr_out[DIGIT_W-1:0]) - DIGIT_W'(1)))
        && (ptr_out[PTR_W-1:DIGIT_W] == $past(ptr_out[PTR_W-1:DIGIT_W])));

    a_r3_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'd12 && no_ld) |=> $stable(ptr_out));

    a_r6_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'd15 && no_ld) |=> $stable(ptr_out));

    a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'd15) |-> (rd_data == '0));

    a_r8_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld_full |=> (ptr_out == DATA_W'($past(ptr_full_in))));
endmodule

bind sp_scratch sp_scratch_chk #(.DIGIT_W(DIGIT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .rd_en(rd_en), .wr_en(wr_en),
    .rd_data(rd_data), .ptr_ld_hi(ptr_ld_hi), .ptr_ld_lo(ptr_ld_lo),
    .ptr_ld_full(ptr_ld_full), .ptr_full_in(ptr_full_in), .ptr_out(ptr_out)
);

// File: tb/sim_sp_scratch.sv
`timescale 1ns/1ps
module sim_sp_scratch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sel_code = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        pair_sel = 1'b0, pair_wr_en = 1'b0;
    logic [15:0] pair_wr_data = '0;
    logic [15:0] pair_rd_data;
    logic        ptr_ld_hi = 1'b0, ptr_ld_lo = 1'b0, ptr_ld_full = 1'b0;
    logic [2:0]  ptr_digit = '0;
    logic [5:0]  ptr_full_in = '0;
    logic [7:0]  ptr_out;
    logic        lo_not7;

    always #2.5 clk = ~clk;

    sp_scratch u0 (.*);

    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;
    logic [7:0] m_mem [64];
    logic [5:0] m_ptr;
    string ptr_tag = "R1";

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [5:0] f_addr(input logic [3:0] c, input logic [5:0] p);
        return (c < 4'd12) ? {2'b00, c} : p;
    endfunction

    // compare outputs against model in the current cycle (called after negedge)
    task automatic compare_now();
        string rtag;
        logic [7:0] exp_rd;
        int b;
        rtag   = (sel_code < 4'd12) ? "R2" : (sel_code == 4'd15) ? "R6" : "R3";
        exp_rd = (sel_code == 4'd15) ? 8'h00 : m_mem[f_addr(sel_code, m_ptr)];
        chk(rtag, "rd_data", {8'h00, rd_data}, {8'h00, exp_rd});
        b = pair_sel ? 14 : 12;
        chk("R10", "pair_rd_data", pair_rd_data, {m_mem[b], m_mem[b+1]});
        chk(ptr_tag, "ptr_out", {8'h00, ptr_out}, {10'h000, m_ptr});
        chk("R9", "lo_not7", {15'h0, lo_not7}, {15'h0, (m_ptr[2:0] != 3'd7)});
    endtask

    task automatic step(input logic [3:0] c, input logic r, input logic w, input logic [7:0] wd,
                        input logic ps, input logic pwe, input logic [15:0] pwd,
                        input logic lh, input logic ll, input logic [2:0] dg,
                        input logic lf, input logic [5:0] fi);
        logic [2:0] nh, nl;
        logic [5:0] a;
        int b;
        sel_code = c; rd_en = r; wr_en = w; wr_data = wd;
        pair_sel = ps; pair_wr_en = pwe; pair_wr_data = pwd;
        ptr_ld_hi = lh; ptr_ld_lo = ll; ptr_digit = dg; ptr_ld_full = lf; ptr_full_in = fi;
        #1;
        compare_now();
        @(posedge clk);
        a = f_addr(c, m_ptr);
        b = ps ? 14 : 12;
        if (pwe) begin
            m_mem[b]   = pwd[15:8];
            m_mem[b+1] = pwd[7:0];
        end
        if (w && c != 4'd15) m_mem[a] = wd;
        nh = m_ptr[5:3]; nl = m_ptr[2:0];
        ptr_tag = "R3";
        if ((r || w) && c == 4'd13) begin nl = nl + 3'd1; ptr_tag = "R4"; end
        if ((r || w) && c == 4'd14) begin nl = nl - 3'd1; ptr_tag = "R5"; end
        if (lh || ll) ptr_tag = "R7";
        if (lh) nh = dg;
        if (ll) nl = dg;
        m_ptr = {nh, nl};
        if (lf) begin m_ptr = fi; ptr_tag = "R8"; end
        @(negedge clk);
    endtask

    task automatic idle();
        step(4'd0, 0, 0, 8'h00, 0, 0, 16'h0, 0, 0, 3'd0, 0, 6'd0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
        m_ptr = 6'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state through every directly reachable register and the pointer
        for (int i = 0; i < 12; i++) begin
            sel_code = 4'(i); #1;
            chk("R1", "reset register", {8'h00, rd_data}, 16'h0000);
            @(negedge clk);
        end
        chk("R1", "reset pointer", {8'h00, ptr_out}, 16'h0000);
        pair_sel = 1'b1; #1;
        chk("R1", "reset pair", pair_rd_data, 16'h0000);
        @(negedge clk);

        // R4: step up from low digit 7 wraps without carry; read sees old address
        step(4'd0, 0, 0, 8'h00, 0, 1, 16'hC3A5, 0, 0, 3'd0, 1, 6'o17);
        step(4'd13, 1, 0, 8'h00, 0, 0, 16'h0, 0, 0, 3'd0, 0, 6'd0);
        chk("R4", "wrap up pointer", {8'h00, ptr_out}, 16'o10);
        // R5: step down from low digit 0 wraps without borrow
        step(4'd0, 0, 0, 8'h00, 0, 0, 16'h0, 0, 0, 3'd0, 1, 6'o20);
        step(4'd14, 0, 1, 8'h5A, 0, 0, 16'h0, 0, 0, 3'd0, 0, 6'd0);
        chk("R5", "wrap down pointer", {8'h00, ptr_out}, 16'o27);
        // R6: reserved code does not write
        step(4'd0, 0, 0, 8'h00, 0, 0, 16'h0, 0, 0, 3'd0, 1, 6'd3);
        step(4'd15, 1, 1, 8'hAA, 0, 0, 16'h0, 0, 0, 3'd0, 0, 6'd0);
        step(4'd12, 1, 0, 8'h00, 0, 0, 16'h0, 0, 0, 3'd0, 0, 6'd0);
        sel_code = 4'd3; #1;
        chk("R6", "register after reserved write", {8'h00, rd_data}, 16'h0000);
        @(negedge clk);
        // R7: lower-digit load overrides step, upper digit load independent
        step(4'd13, 1, 0, 8'h00, 0, 0, 16'h0, 0, 1, 3'd5, 0, 6'd0);
        step(4'd0, 0, 0, 8'h00, 0, 0, 16'h0, 1, 0, 3'd6, 0, 6'd0);
        chk("R7", "digit loads", {8'h00, ptr_out}, 16'o65);
        // R10: byte write wins over pair write on the same register
        step(4'd0, 0, 0, 8'h00, 0, 0, 16'h0, 0, 0, 3'd0, 1, 6'd15);
        step(4'd12, 0, 1, 8'h77, 1, 1, 16'h1122, 0, 0, 3'd0, 0, 6'd0);
        pair_sel = 1'b1; #1;
        chk("R10", "pair collision", pair_rd_data, 16'h1177);
        @(negedge clk);
        // R8: full load overrides digit loads and step
        step(4'd13, 1, 0, 8'h00, 0, 0, 16'h0, 1, 1, 3'd1, 1, 6'o42);
        chk("R8", "full load priority", {8'h00, ptr_out}, 16'o42);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            step(4'($urandom % 16), 1'($urandom % 2), 1'(($urandom % 3) == 0), 8'($urandom),
                 1'($urandom % 2), 1'(($urandom % 8) == 0), 16'($urandom),
                 1'(($urandom % 10) == 0), 1'(($urandom % 10) == 0), 3'($urandom),
                 1'(($urandom % 16) == 0), 6'($urandom));
        end
        idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule